// File: doc/BRIEF.md
# Adder-Based ALU with Registered Flags

This block is an eight-bit arithmetic and logic unit. A single ripple-carry adder produces every arithmetic result. The first operand goes straight into the adder. The second operand passes through a four-way selector that supplies zero, the operand itself, its bitwise inverse, or all ones. The lowest select bit serves as the adder's carry-in. The top select bit switches the output to a bitwise logic section instead. The result output is combinational. It is valid as soon as the operands and the select code settle.

Three condition bits are held in registers: zero, sign and carry. They load only on a clock edge on which the update strobe is high, and reset clears them. A surrounding controller typically presents the operands, pulses the update strobe in the same cycle, and reads the flags from the next cycle onward.

Top module: `alu_flags_unit`

## Requirements
- R1: For opSel[3]=0 the result is (opA + X + opSel[0]) mod 256, where X is 00h for opSel[2:1]=00, opB for 01, ~opB for 10 and FFh for 11; this also holds for the codes 0000, 0011, 0100 and 0111.
- R2: opSel=0001 yields opA+1.
- R3: opSel=0010 yields opA+opB.
- R4: opSel=0101 yields opA-opB, and the carry flag is 1 when no borrow occurs (opA >= opB).
- R5: opSel=0110 yields opA-1, and the carry flag is 1 unless opA is 00h.
- R6: For opSel[3]=1, opSel[2:1] picks OR (00), XOR (01), AND (10) or the inverse of opA (11); opSel[0] has no effect on the result or the flags.
- R7: After a flag update the zero flag is 1 exactly when all eight result bits were 0.
- R8: After a flag update the sign flag equals bit 7 of the result.
- R9: After a flag update the carry flag equals the carry out of the top adder stage for arithmetic codes and is 0 for logic codes.
- R10: While flagUpdate is 0 the flags keep their values across clock edges, whatever the operands and select code are.
- R11: An active-low reset clears all three flags.
- R12: The result follows operand and select changes without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag registers |
| rstN | input | 1 | Asynchronous active-low reset |
| opA | input | 8 | First operand, straight into the adder and the logic section |
| opB | input | 8 | Second operand, through the selector |
| opSel | input | 4 | Function select code |
| flagUpdate | input | 1 | Flags load on the next rising edge when high |
| result | output | 8 | Combinational result |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |
| carryFlag | output | 1 | Registered carry flag |

## Verification
Every arithmetic code, the four unlisted ones included, is applied with operand pairs that do and do not carry out of bit 7. These pairs separate a wrong selector leg from a wrong carry-in. Subtraction is tried with the minuend above, equal to and below the subtrahend, and decrement with opA at 01h and 00h. This pins down the sense of the carry flag. Each logic function is applied with both values of the low select bit. A logic code follows an operation that set the carry, to show that the carry clears. A stretch with the update strobe low and flag-changing operands confirms that the flags hold while the result still moves.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

  typedef enum logic [1:0] {
    OPB_ZERO = 2'b00,
    OPB_TRUE = 2'b01,
    OPB_INV  = 2'b10,
    OPB_ONES = 2'b11
  } opbSel_e;

  typedef enum logic [1:0] {
    LOGIC_OR  = 2'b00,
    LOGIC_XOR = 2'b01,
    LOGIC_AND = 2'b10,
    LOGIC_NOT = 2'b11
  } logicOp_e;

  typedef struct packed {
    logic     isLogic;
    opbSel_e  opbSel;
    logic     carryIn;
    logicOp_e logicOp;
    logic     flagLoad;
  } aluStrobes_t;

  localparam int SEL_W = 4;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_flags_pkg::*;
(
  input  logic [SEL_W-1:0] opSel,
  input  logic             flagUpdate,
  output aluStrobes_t      strobes
);

  always_comb begin
    strobes.isLogic  = opSel[3];
    strobes.opbSel   = opbSel_e'(opSel[2:1]);
    strobes.carryIn  = opSel[3] ? 1'b0 : opSel[0];
    strobes.logicOp  = logicOp_e'(opSel[2:1]);
    strobes.flagLoad = flagUpdate;
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             carryFlag
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addInB;
  logic [WIDTH-1:0] sumBits;
  logic [WIDTH:0]   carryChain;
  logic [WIDTH-1:0] logicOut;
  logic             carryOut;

  // operand selector: zero / true / complement / ones
  always_comb begin
    unique case (strobes.opbSel)
      OPB_ZERO: addInB = '0;
      OPB_TRUE: addInB = opB;
      OPB_INV:  addInB = ~opB;
      default:  addInB = '1;
    endcase
  end

  // ripple adder, one full-adder stage per bit
  assign carryChain[0] = strobes.carryIn;
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    assign sumBits[i]      = opA[i] ^ addInB[i] ^ carryChain[i];
    assign carryChain[i+1] = (opA[i] & addInB[i]) | (carryChain[i] & (opA[i] ^ addInB[i]));
  end
  assign carryOut = carryChain[WIDTH];

  // logic section
  always_comb begin
    unique case (strobes.logicOp)
      LOGIC_OR:  logicOut = opA | opB;
      LOGIC_XOR: logicOut = opA ^ opB;
      LOGIC_AND: logicOut = opA & opB;
      default:   logicOut = ~opA;
    endcase
  end

  assign result = strobes.isLogic ? logicOut : sumBits;

  // flag registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroFlag  <= 1'b0;
      signFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else if (strobes.flagLoad) begin
      zeroFlag  <= (result == '0);
      signFlag  <= result[MSB];
      carryFlag <= strobes.isLogic ? 1'b0 : carryOut;
    end
  end

  AST_RIPPLE_SUM: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.isLogic |-> {carryOut, sumBits} == ({1'b0, opA} + {1'b0, addInB} + {{WIDTH{1'b0}}, strobes.carryIn})); // R1

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagLoad |=> $stable({zeroFlag, signFlag, carryFlag})); // R10

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagLoad |=> zeroFlag == ($past(result) == '0)); // R7

  AST_SIGN_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagLoad |=> signFlag == $past(result[MSB])); // R8

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagLoad && strobes.isLogic |=> !carryFlag); // R9

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [SEL_W-1:0] opSel,
  input  logic             flagUpdate,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             carryFlag
);

  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opSel      (opSel),
    .flagUpdate (flagUpdate),
    .strobes    (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .opA       (opA),
    .opB       (opB),
    .strobes   (strobes),
    .result    (result),
    .zeroFlag  (zeroFlag),
    .signFlag  (signFlag),
    .carryFlag (carryFlag)
  );

endmodule

// File: tb/alu_flags_unit_bench.sv
`timescale 1ns/1ps
module alu_flags_unit_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0;
  logic [7:0] opB = '0;
  logic [3:0] opSel = '0;
  logic       flagUpdate = 1'b0;
  logic [7:0] result;
  logic       zeroFlag, signFlag, carryFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  alu_flags_unit u_alu_flags_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .opSel(opSel),
    .flagUpdate(flagUpdate), .result(result),
    .zeroFlag(zeroFlag), .signFlag(signFlag), .carryFlag(carryFlag)
  );

  // {opSel, opA, opB, expResult, expZ, expS, expC}
  localparam int NV = 22;
  localparam logic [30:0] VECS [NV] = '{
    {4'h1, 8'h3C, 8'h00, 8'h3D, 3'b000},
    {4'h1, 8'hFF, 8'h00, 8'h00, 3'b101},
    {4'h8, 8'hA0, 8'h05, 8'hA5, 3'b010},
    {4'h2, 8'h10, 8'h40, 8'h50, 3'b000},
    {4'h2, 8'h80, 8'h80, 8'h00, 3'b101},
    {4'hB, 8'h5A, 8'h5A, 8'h00, 3'b100},
    {4'h2, 8'h7F, 8'h01, 8'h80, 3'b010},
    {4'h5, 8'h50, 8'h10, 8'h40, 3'b001},
    {4'h9, 8'hA0, 8'h05, 8'hA5, 3'b010},
    {4'h5, 8'h10, 8'h50, 8'hC0, 3'b010},
    {4'h5, 8'h33, 8'h33, 8'h00, 3'b101},
    {4'hE, 8'h00, 8'h12, 8'hFF, 3'b010},
    {4'h6, 8'h01, 8'h00, 8'h00, 3'b101},
    {4'h6, 8'h00, 8'h00, 8'hFF, 3'b010},
    {4'hA, 8'hF0, 8'hFF, 8'h0F, 3'b000},
    {4'hC, 8'hF0, 8'h3C, 8'h30, 3'b000},
    {4'hD, 8'h0F, 8'hF0, 8'h00, 3'b100},
    {4'hF, 8'hFF, 8'h00, 8'h00, 3'b100},
    {4'h0, 8'h42, 8'h99, 8'h42, 3'b000},
    {4'h3, 8'h10, 8'h20, 8'h31, 3'b000},
    {4'h4, 8'h10, 8'h20, 8'hEF, 3'b010},
    {4'h7, 8'h10, 8'h20, 8'h10, 3'b001}
  };

  function automatic string reqFor(input logic [3:0] op);
    case (op)
      4'h1: return "R2";
      4'h2: return "R3";
      4'h5: return "R4";
      4'h6: return "R5";
      4'h0, 4'h3, 4'h4, 4'h7: return "R1";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic checkFlags(input string req, input logic [2:0] exp);
    check({req, "/R7"}, "zero", {7'd0, zeroFlag},  {7'd0, exp[2]});
    check({req, "/R8"}, "sign", {7'd0, signFlag},  {7'd0, exp[1]});
    check({req, "/R9"}, "carry", {7'd0, carryFlag}, {7'd0, exp[0]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    checkFlags("R11", 3'b000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      opSel = VECS[i][30:27];
      opA   = VECS[i][26:19];
      opB   = VECS[i][18:11];
      flagUpdate = 1'b1;
      #1;
      check(reqFor(opSel), "result", result, VECS[i][10:3]);
      @(negedge clk);
      flagUpdate = 1'b0;
      checkFlags(reqFor(opSel), VECS[i][2:0]);
    end

    // establish flags Z=0 S=1 C=1: SUB 10h-50h gives C0 no carry; use DEC 00h? use 0111 with A=F0
    @(negedge clk);
    opSel = 4'h7; opA = 8'hF0; opB = 8'h00; flagUpdate = 1'b1;   // F0+FF+1 = 1F0
    @(negedge clk);
    flagUpdate = 1'b0;
    checkFlags("R1", 3'b011);

    // R10/R12: strobe low, result moves, flags hold
    opSel = 4'h2; opA = 8'h00; opB = 8'h00;
    #1;
    check("R12", "result no clock", result, 8'h00);
    repeat (3) @(negedge clk);
    checkFlags("R10", 3'b011);
    opSel = 4'hE; opA = 8'h80;
    #1;
    check("R12", "result no clock", result, 8'h7F);
    @(negedge clk);
    checkFlags("R10", 3'b011);

    // R11: reset in mid-run clears flags
    rstN = 1'b0;
    #1;
    checkFlags("R11", 3'b000);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkFlags("R11", 3'b000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule